// File: doc/BRIEF.md
# Configurable memory-map chip-select decoder

This block turns a 20-bit latched bus address and the bus read and write strobes into select lines. It drives eight select lines for the 4 KB program-memory blocks, one select line for a 2 KB data-RAM block, and eleven chip selects for external peripherals. Each program block and the RAM block has its own base register. Each of these windows can be enabled or disabled on its own, so a 1 MB space can be filled with windows placed anywhere on their own size boundary.

Each external select comes from a programmable match term. A term compares the address against a match value under a don't-care mask. It can also require a chosen level on the read strobe, the write strobe, or both, which gives selects that assert only during a write. A power-down input blanks every memory select. The external terms never see this input.

Configuration goes through a simple register write port with a combinational read-back path. Setting the lock flag hides every register from the read-back path until the next reset. The address decode is purely combinational from the registered configuration.

Top module: `csd_decoder`

## Requirements
- R1: After reset every window and every term is disabled and the lock flag is clear. No select output is active for any bus input, and register 0 reads back as zero.
- R2: Register i (0 to 7) holds program block i: base in bits [7:0] and enable in bit 8. `prog_sel[i]` is active when the block is enabled and `bus_addr[19:12]` equals its base, subject to R4 and R5.
- R3: Register 8 holds the RAM window: base in bits [8:0] and enable in bit 9. `ram_sel` is active when the window is enabled and `bus_addr[19:11]` equals its base, subject to R5.
- R4: When several memory windows match, the RAM wins first and then the lowest-numbered program block. At most one memory select is active at a time.
- R5: While `pd_in` is high, `ram_sel` and every bit of `prog_sel` are low, whatever the configuration.
- R6: Term j uses register 16+2j: match value in bits [19:0] and enable in bit 22. It also uses register 17+2j: don't-care mask in bits [19:0], where a 1 means "ignore this bit". An enabled term matches when every non-masked address bit equals the match bit.
- R7: Register 16+2j bit 21 makes term j require `bus_rd` to equal bit 20 of that register. Register 17+2j bit 21 makes it require `bus_wr` to equal bit 20 of that register. A term's select is active only when its address match and every enabled strobe requirement hold.
- R8: `pd_in` has no effect on any external chip select.
- R9: While unlocked, each register reads back its written fields with all other bits zero. Writing 1 to bit 0 of register 9 sets the lock flag, and only reset clears it. While locked, every read returns zero and address decoding keeps working.
- R10: Terms 0 to 7 drive `cs_lo[0]` to `cs_lo[7]`. Terms 8 to 10 drive `cs_hi[0]` to `cs_hi[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration register index |
| cfg_wdata | input | 23 | Configuration write data |
| cfg_rdata | output | 23 | Read-back of the register at cfg_addr |
| bus_addr | input | 20 | Latched bus address |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| pd_in | input | 1 | Power-down input, high blanks memory selects |
| prog_sel | output | 8 | Program block selects |
| ram_sel | output | 1 | Data-RAM select |
| cs_lo | output | 8 | External chip selects from terms 0 to 7 |
| cs_hi | output | 3 | External chip selects from terms 8 to 10 |

## Verification
A wrong base, enable or mask bit in the configuration shows up on the select outputs in the same cycle the address is presented. It appears as a missing select, a stray select, or two memory selects at once. A register update that lands in the wrong field shows one cycle after the write, both in the read-back and in the decode. A lock flag that clears, or that fails to set, shows at once as non-zero read data or as read data forced to zero. Sweeping every 2 KB address chunk against overlapping windows, with power-down on and off, exposes priority faults and power-down leaks at the first address that hits them.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W      = 20;
    localparam int PROG_BLK_AW = 12;
    localparam int RAM_AW      = 11;
    localparam int N_PROG      = 8;
    localparam int N_CS_LO     = 8;
    localparam int N_CS_HI     = 3;
    localparam int N_CS        = N_CS_LO + N_CS_HI;
    localparam int CFG_AW      = 6;
    localparam int CFG_W       = ADDR_W + 3;
    localparam int PROG_BASE_W = ADDR_W - PROG_BLK_AW;
    localparam int RAM_BASE_W  = ADDR_W - RAM_AW;
    localparam int RAM_IDX     = N_PROG;
    localparam int LOCK_IDX    = N_PROG + 1;
    localparam int TERM_BASE   = 16;

    typedef struct packed {
        logic                   en;
        logic [PROG_BASE_W-1:0] base;
    } prog_win_t;

    typedef struct packed {
        logic                  en;
        logic [RAM_BASE_W-1:0] base;
    } ram_win_t;

    typedef struct packed {
        logic              en;
        logic              rd_care;
        logic              rd_lvl;
        logic [ADDR_W-1:0] match;
        logic              wr_care;
        logic              wr_lvl;
        logic [ADDR_W-1:0] mask;
    } term_t;
endpackage

// File: rtl/csd_win_match.sv
module csd_win_match #(
    parameter int BASE_W = 8
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic              en,
    input  logic [BASE_W-1:0] base,
    input  logic              pd,
    output logic              hit
);
    always_comb begin
        hit = en && !pd && (addr_hi == base);
    end
endmodule

// File: rtl/csd_term.sv
module csd_term
    import csd_pkg::*;
(
    input  term_t             cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit
);
    logic addr_ok, rd_ok, wr_ok;

    always_comb begin
        addr_ok = (((addr ^ cfg.match) & ~cfg.mask) == '0);
        rd_ok   = !cfg.rd_care || (rd == cfg.rd_lvl);
        wr_ok   = !cfg.wr_care || (wr == cfg.wr_lvl);
        hit     = cfg.en && addr_ok && rd_ok && wr_ok;
    end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int N = 9
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i] && !taken;
            taken  = taken || req[i];
        end
    end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
    import csd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              pd_in,
    output logic [N_PROG-1:0] prog_sel,
    output logic              ram_sel,
    output logic [N_CS_LO-1:0] cs_lo,
    output logic [N_CS_HI-1:0] cs_hi
);
    typedef struct packed {
        prog_win_t [N_PROG-1:0] prog;
        ram_win_t               ram;
        term_t     [N_CS-1:0]   term;
        logic                   lock;
    } state_t;

    state_t st_d, st_q;

    // next-state: configuration writes
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < N_PROG; i++) begin
                if (cfg_addr == CFG_AW'(i)) begin
                    st_d.prog[i].base = cfg_wdata[PROG_BASE_W-1:0];
                    st_d.prog[i].en   = cfg_wdata[PROG_BASE_W];
                end
            end
            if (cfg_addr == CFG_AW'(RAM_IDX)) begin
                st_d.ram.base = cfg_wdata[RAM_BASE_W-1:0];
                st_d.ram.en   = cfg_wdata[RAM_BASE_W];
            end
            if (cfg_addr == CFG_AW'(LOCK_IDX) && cfg_wdata[0]) begin
                st_d.lock = 1'b1;
            end
            for (int j = 0; j < N_CS; j++) begin
                if (cfg_addr == CFG_AW'(TERM_BASE + 2*j)) begin
                    st_d.term[j].match   = cfg_wdata[ADDR_W-1:0];
                    st_d.term[j].rd_lvl  = cfg_wdata[ADDR_W];
                    st_d.term[j].rd_care = cfg_wdata[ADDR_W+1];
                    st_d.term[j].en      = cfg_wdata[ADDR_W+2];
                end
                if (cfg_addr == CFG_AW'(TERM_BASE + 2*j + 1)) begin
                    st_d.term[j].mask    = cfg_wdata[ADDR_W-1:0];
                    st_d.term[j].wr_lvl  = cfg_wdata[ADDR_W];
                    st_d.term[j].wr_care = cfg_wdata[ADDR_W+1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read-back, hidden when locked
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < N_PROG; i++) begin
            if (cfg_addr == CFG_AW'(i)) cfg_rdata = CFG_W'(st_q.prog[i]);
        end
        if (cfg_addr == CFG_AW'(RAM_IDX))  cfg_rdata = CFG_W'(st_q.ram);
        if (cfg_addr == CFG_AW'(LOCK_IDX)) cfg_rdata = CFG_W'(st_q.lock);
        for (int j = 0; j < N_CS; j++) begin
            if (cfg_addr == CFG_AW'(TERM_BASE + 2*j))
                cfg_rdata = {st_q.term[j].en, st_q.term[j].rd_care,
                             st_q.term[j].rd_lvl, st_q.term[j].match};
            if (cfg_addr == CFG_AW'(TERM_BASE + 2*j + 1))
                cfg_rdata = {1'b0, st_q.term[j].wr_care,
                             st_q.term[j].wr_lvl, st_q.term[j].mask};
        end
        if (st_q.lock) cfg_rdata = '0;
    end

    // memory windows: bit 0 is RAM, bits 1..N_PROG are program blocks
    logic [N_PROG:0] mem_req, mem_gnt;

    csd_win_match #(.BASE_W(RAM_BASE_W)) u_ram_win (
        .addr_hi (bus_addr[ADDR_W-1:RAM_AW]),
        .en      (st_q.ram.en),
        .base    (st_q.ram.base),
        .pd      (pd_in),
        .hit     (mem_req[0])
    );

    for (genvar i = 0; i < N_PROG; i++) begin : g_prog
        csd_win_match #(.BASE_W(PROG_BASE_W)) u_win (
            .addr_hi (bus_addr[ADDR_W-1:PROG_BLK_AW]),
            .en      (st_q.prog[i].en),
            .base    (st_q.prog[i].base),
            .pd      (pd_in),
            .hit     (mem_req[i+1])
        );
    end

    csd_prio #(.N(N_PROG+1)) u_prio (
        .req (mem_req),
        .gnt (mem_gnt)
    );

    assign ram_sel  = mem_gnt[0];
    assign prog_sel = mem_gnt[N_PROG:1];

    logic [N_CS-1:0] term_hit;

    for (genvar j = 0; j < N_CS; j++) begin : g_term
        csd_term u_term (
            .cfg  (st_q.term[j]),
            .addr (bus_addr),
            .rd   (bus_rd),
            .wr   (bus_wr),
            .hit  (term_hit[j])
        );
    end

    assign cs_lo = term_hit[N_CS_LO-1:0];
    assign cs_hi = term_hit[N_CS-1:N_CS_LO];
endmodule

// File: rtl/csd_decoder_chk.sv
module csd_decoder_chk
    import csd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pd_in,
    input logic               lock,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic [N_PROG-1:0]  prog_sel,
    input logic               ram_sel,
    input logic [N_CS_LO-1:0] cs_lo,
    input logic [N_CS_HI-1:0] cs_hi
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (prog_sel == '0 && !ram_sel && cs_lo == '0 && cs_hi == '0));

    p_single_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_sel, ram_sel}));

    p_pd_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_in |-> (prog_sel == '0 && !ram_sel));

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    p_lock_hides_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (cfg_rdata == '0));
endmodule

bind csd_decoder csd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_in     (pd_in),
    .lock      (st_q.lock),
    .cfg_rdata (cfg_rdata),
    .prog_sel  (prog_sel),
    .ram_sel   (ram_sel),
    .cs_lo     (cs_lo),
    .cs_hi     (cs_hi)
);

// File: tb/csd_decoder_tb_top.sv
module csd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [22:0] cfg_wdata = '0;
    logic [22:0] cfg_rdata;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, pd_in = 1'b0;
    logic [7:0]  prog_sel;
    logic        ram_sel;
    logic [7:0]  cs_lo;
    logic [2:0]  cs_hi;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    csd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .pd_in(pd_in), .prog_sel(prog_sel),
        .ram_sel(ram_sel), .cs_lo(cs_lo), .cs_hi(cs_hi)
    );

    // bench copy of intended configuration
    logic [7:0]  pb_base [8];
    logic        pb_en   [8];
    logic [8:0]  rm_base;
    logic        rm_en;
    logic        t_en [11], t_rc [11], t_rl [11], t_wc [11], t_wl [11];
    logic [19:0] t_m [11], t_k [11];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [22:0] d);
        @(negedge clk);
        cfg_addr = 6'(a); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [22:0] exp, input string req);
        cfg_addr = 6'(a);
        #1;
        chk(cfg_rdata === exp, req, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic set_prog(input int i, input logic en, input logic [7:0] b);
        pb_en[i] = en; pb_base[i] = b;
        wr_reg(i, {14'd0, en, b});
    endtask

    task automatic set_ram(input logic en, input logic [8:0] b);
        rm_en = en; rm_base = b;
        wr_reg(8, {13'd0, en, b});
    endtask

    task automatic set_term(input int j, input logic en, input logic [19:0] m,
                            input logic [19:0] k, input logic rc, input logic rl,
                            input logic wc, input logic wl);
        t_en[j] = en; t_m[j] = m; t_k[j] = k;
        t_rc[j] = rc; t_rl[j] = rl; t_wc[j] = wc; t_wl[j] = wl;
        wr_reg(16 + 2*j, {en, rc, rl, m});
        wr_reg(17 + 2*j, {1'b0, wc, wl, k});
    endtask

    // R2 R3 R4 R5: expected memory selects
    task automatic mem_chk(input logic [19:0] a, input logic pd);
        logic [8:0] exp;
        logic       taken;
        bus_addr = a; pd_in = pd;
        #1;
        exp = '0; taken = 1'b0;
        if (!pd && rm_en && a[19:11] == rm_base) begin exp[0] = 1'b1; taken = 1'b1; end
        for (int i = 0; i < 8; i++) begin
            if (!pd && !taken && pb_en[i] && a[19:12] == pb_base[i]) begin
                exp[i+1] = 1'b1; taken = 1'b1;
            end
        end
        chk({prog_sel, ram_sel} === exp, pd ? "R5 power-down" : "R2/R3/R4 window decode",
            32'({prog_sel, ram_sel}), 32'(exp));
    endtask

    // R6 R7 R8 R10: expected external selects
    task automatic cs_chk(input logic [19:0] a, input logic rd, input logic wr,
                          input logic pd);
        logic [10:0] exp;
        bus_addr = a; bus_rd = rd; bus_wr = wr; pd_in = pd;
        #1;
        for (int j = 0; j < 11; j++) begin
            exp[j] = t_en[j] && (((a ^ t_m[j]) & ~t_k[j]) == 20'd0)
                     && (!t_rc[j] || rd == t_rl[j]) && (!t_wc[j] || wr == t_wl[j]);
        end
        chk({cs_hi, cs_lo} === exp, "R6/R7/R8/R10 external selects",
            32'({cs_hi, cs_lo}), 32'(exp));
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin pb_en[i] = 0; pb_base[i] = 0; end
        rm_en = 0; rm_base = 0;
        for (int j = 0; j < 11; j++) begin
            t_en[j] = 0; t_m[j] = 0; t_k[j] = 0;
            t_rc[j] = 0; t_rl[j] = 0; t_wc[j] = 0; t_wl[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, across address and strobe patterns
        for (int k = 0; k < 16; k++) begin
            bus_addr = 20'(k * 65537); bus_rd = k[0]; bus_wr = k[1]; pd_in = 1'b0;
            #1;
            chk(prog_sel === 8'd0 && ram_sel === 1'b0 && cs_lo === 8'd0 && cs_hi === 3'd0,
                "R1 reset selects", 32'({cs_hi, cs_lo, prog_sel, ram_sel}), 0);
        end
        rd_chk(0, 23'd0, "R1 reset readback");
        rd_chk(9, 23'd0, "R1 reset lock");

        // windows: blocks 5 and 6 share a base; RAM sits in upper half of block 2
        for (int i = 0; i < 8; i++) set_prog(i, 1'b1, 8'(8'h20 + i * 7));
        set_prog(6, 1'b1, 8'h43);
        set_prog(7, 1'b0, 8'h10);
        set_ram(1'b1, {8'h2E, 1'b1});
        for (int a9 = 0; a9 < 512; a9++) begin
            mem_chk({9'(a9), 11'h5A5}, 1'b0);
            mem_chk({9'(a9), 11'h05A}, 1'b1);
        end
        // RAM disabled: block 2 regains its upper half
        set_ram(1'b0, {8'h2E, 1'b1});
        for (int a9 = 0; a9 < 512; a9++) mem_chk({9'(a9), 11'h123}, 1'b0);
        // RAM moved onto block 5/6 overlap
        set_ram(1'b1, 9'h086);
        for (int a9 = 128; a9 < 144; a9++) mem_chk({9'(a9), 11'h7FF}, 1'b0);
        // block 5 disabled: block 6 takes the shared base (R4)
        set_prog(5, 1'b0, 8'h43);
        for (int a9 = 134; a9 < 136; a9++) mem_chk({9'(a9), 11'h001}, 1'b0);

        // external terms
        set_term(0, 1, 20'h40000, 20'h0FFFF, 0, 0, 0, 0);
        set_term(1, 1, 20'h12345, 20'h00000, 0, 0, 0, 0);
        set_term(2, 1, 20'h80000, 20'h7FFFF, 0, 0, 1, 1);
        set_term(3, 1, 20'h00000, 20'hFFFFF, 1, 1, 0, 0);
        set_term(4, 1, 20'hABC00, 20'h000FF, 1, 0, 1, 0);
        set_term(8, 1, 20'h30000, 20'h00FFF, 0, 0, 0, 0);
        set_term(10, 1, 20'hFFFFF, 20'h0000F, 0, 0, 1, 1);
        set_term(9, 0, 20'h00000, 20'hFFFFF, 0, 0, 0, 0);
        for (int s = 0; s < 4; s++) begin
            cs_chk(20'h12345, s[0], s[1], s[0]);
            cs_chk(20'h12344, s[0], s[1], s[1]);
            cs_chk(20'hABC7E, s[0], s[1], 1'b1);
            cs_chk(20'hFFFF3, s[0], s[1], 1'b0);
            cs_chk(20'h30ABC, s[0], s[1], 1'b1);
            cs_chk(20'h4F00F, s[0], s[1], 1'b0);
        end
        for (int k = 0; k < 1024; k++) begin
            cs_chk(20'(k * 4099), k[1], k[2], k[0]);
        end

        // R9: readback while unlocked
        bus_rd = 0; bus_wr = 0; pd_in = 0;
        for (int i = 0; i < 8; i++)
            rd_chk(i, {14'd0, pb_en[i], pb_base[i]}, "R9 program window readback");
        rd_chk(8, {13'd0, rm_en, rm_base}, "R9 RAM window readback");
        for (int j = 0; j < 11; j++) begin
            rd_chk(16 + 2*j, {t_en[j], t_rc[j], t_rl[j], t_m[j]}, "R9 term match readback");
            rd_chk(17 + 2*j, {1'b0, t_wc[j], t_wl[j], t_k[j]}, "R9 term mask readback");
        end
        rd_chk(9, 23'd0, "R9 lock clear before set");
        wr_reg(9, 23'd0);
        rd_chk(9, 23'd0, "R9 writing zero leaves lock clear");
        rd_chk(1, {14'd0, pb_en[1], pb_base[1]}, "R9 still readable");

        // R9: lock hides readback, sticky, decode unaffected
        wr_reg(9, 23'd1);
        rd_chk(1, 23'd0, "R9 locked readback");
        rd_chk(16, 23'd0, "R9 locked term readback");
        wr_reg(9, 23'd0);
        rd_chk(8, 23'd0, "R9 lock sticky");
        mem_chk(20'h21000, 1'b0);
        cs_chk(20'h12345, 1'b0, 1'b0, 1'b0);
        set_prog(0, 1'b1, 8'h77);
        mem_chk(20'h77ABC, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule